// File: doc/BRIEF.md
# Partitioned 128-bit SIMD Integer ALU

This block is a packed integer execution unit. It takes two 128-bit operands and treats them as 16 lanes of 8 bits, 8 lanes of 16 bits or 4 lanes of 32 bits. A lane-size input picks the partition on every operation, so consecutive operations may use different lane widths with no reconfiguration step. The supported operations are add, subtract, minimum, maximum, per-lane shifts, bitwise logic and a per-lane leading-zero count. A funnel shift joins the two operands into a 256-bit value and returns a 128-bit window of it.

The arithmetic path is built from two 64-bit segmented adder halves. Carry propagation between byte segments is cut wherever a lane boundary falls, so the same carry chain serves every lane width. All results pass through a single output register. An operation presented with `in_valid` high appears on `result` one clock later, together with `out_valid`.

Lane `i` of a given lane width `LW` occupies bits `[i*LW +: LW]` of an operand or of the result.

Top module: `simd_alu`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` and `result` are zero. `out_valid` equals the previous cycle's `in_valid`. `result` loads the new value only in a cycle where `in_valid` is high, and holds its value otherwise.
- R2: `lane_sz` selects the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and 3 behaves exactly like 2.
- R3: Operation code 0 adds and code 1 subtracts (`src_a - src_b`) lane by lane. Each lane wraps modulo 2^LW, and no carry or borrow crosses into the neighbouring lane.
- R4: Operation code 2 returns the per-lane minimum and code 3 returns the per-lane maximum of `src_a` and `src_b`. Lanes compare as two's-complement values when `sgn` is 1 and as unsigned values when `sgn` is 0.
- R5: Operation code 4 shifts each lane of `src_a` by the matching lane of `src_b`, using only that lane's low log2(LW) bits (the amount modulo LW). `shift_kind` selects the shift: 0 is logical left, 1 is logical right, 2 is arithmetic right, and 3 is logical left.
- R6: Operation codes 5, 6, 7 and 8 return the bitwise AND, OR, XOR and NOR of the operands. These results do not depend on `lane_sz`.
- R7: Operation code 9 returns, for each lane of `src_a`, the number of leading zero bits, right-justified in the lane with zero upper bits. A zero lane returns LW.
- R8: Operation code 10 forms the 256-bit value {`src_a`, `src_b`}, with `src_a` in the upper half, shifts it right by S and returns the low 128 bits. When `fsh_bytes` is 0, S is `fsh_amt` (0 to 127 bits). When `fsh_bytes` is 1, S is 8 times `fsh_amt[3:0]` (0 to 15 bytes).
- R9: Operation codes 11 to 15 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see requirements) |
| lane_sz | input | 2 | Lane width select: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| sgn | input | 1 | Signed comparison for min/max |
| shift_kind | input | 2 | 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = logical left |
| src_a | input | 128 | First operand; upper half of the funnel input |
| src_b | input | 128 | Second operand, per-lane shift amounts; lower half of the funnel input |
| fsh_amt | input | 7 | Funnel shift amount |
| fsh_bytes | input | 1 | Funnel amount counts bytes (low 4 bits) instead of bits |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 128 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 128-bit datapath split into two 64-bit halves, with 8-bit carry segments. This covers all three lane widths (16, 8 and 4 lanes) and the join between the two halves at bit 64. Directed vectors place carries, borrows and sign bits exactly at lane edges, zero lanes for the count, shift amounts above the lane width, and funnel windows at 0, 64 and 127 bits. A scoreboard also compares a stream of random operations, covering every lane-size code, against a per-lane model written in the bench.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_MIN = 4'd2,
    OP_MAX = 4'd3,
    OP_SHF = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_NOR = 4'd8,
    OP_LZC = 4'd9,
    OP_FSH = 4'd10
  } simd_op_e;

  localparam logic [1:0] SHK_SLL = 2'd0;
  localparam logic [1:0] SHK_SRL = 2'd1;
  localparam logic [1:0] SHK_SRA = 2'd2;

  localparam int NUM_SIZES = 3;

endpackage

// File: rtl/simd_seg_adder.sv
// One half of the add/subtract datapath: a byte-segmented carry chain
// whose segment carries are cut where a lane of the selected width starts.
module simd_seg_adder #(
  parameter int W     = 64,
  parameter int SEG_W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic [1:0]   wsel,
  output logic [W-1:0] sum
);
  localparam int NSEG = W / SEG_W;

  always_comb begin
    logic             carry;
    logic [SEG_W:0]   t;
    logic [SEG_W-1:0] bs;
    carry = sub;
    sum   = '0;
    for (int j = 0; j < NSEG; j++) begin
      if ((j % (1 << wsel)) == 0) carry = sub;
      bs = b[j*SEG_W +: SEG_W] ^ {SEG_W{sub}};
      t  = {1'b0, a[j*SEG_W +: SEG_W]} + {1'b0, bs} + {{SEG_W{1'b0}}, carry};
      sum[j*SEG_W +: SEG_W] = t[SEG_W-1:0];
      carry = t[SEG_W];
    end
  end

endmodule

// File: rtl/simd_lane_ops.sv
// Per-lane compare, shift and leading-zero logic for one fixed lane width.
module simd_lane_ops
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sgn,
  input  logic [1:0]        shift_kind,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] max_o,
  output logic [DATA_W-1:0] shf_o,
  output logic [DATA_W-1:0] lzc_o
);
  localparam int NLANE = DATA_W / LANE_W;
  localparam int AMT_W = $clog2(LANE_W);
  localparam int CNT_W = AMT_W + 1;

  function automatic logic [CNT_W-1:0] lead_zeros(input logic [LANE_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = CNT_W'(LANE_W);
    for (int i = 0; i < LANE_W; i++)
      if (v[i]) n = CNT_W'(LANE_W - 1 - i);
    return n;
  endfunction

  always_comb begin
    logic [LANE_W-1:0] x, y;
    logic [AMT_W-1:0]  s;
    logic              a_lt_b;
    min_o = '0;
    max_o = '0;
    shf_o = '0;
    lzc_o = '0;
    for (int l = 0; l < NLANE; l++) begin
      x = a[l*LANE_W +: LANE_W];
      y = b[l*LANE_W +: LANE_W];
      s = y[AMT_W-1:0];
      a_lt_b = sgn ? ($signed(x) < $signed(y)) : (x < y);
      min_o[l*LANE_W +: LANE_W] = a_lt_b ? x : y;
      max_o[l*LANE_W +: LANE_W] = a_lt_b ? y : x;
      case (shift_kind)
        SHK_SRL: shf_o[l*LANE_W +: LANE_W] = x >> s;
        SHK_SRA: shf_o[l*LANE_W +: LANE_W] = LANE_W'($signed(x) >>> s);
        default: shf_o[l*LANE_W +: LANE_W] = x << s;
      endcase
      lzc_o[l*LANE_W +: LANE_W] = LANE_W'(lead_zeros(x));
    end
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane_chk
    logic [LANE_W-1:0] a_l, lz_l, mn_l, mx_l;
    assign a_l  = a[l*LANE_W +: LANE_W];
    assign lz_l = lzc_o[l*LANE_W +: LANE_W];
    assign mn_l = min_o[l*LANE_W +: LANE_W];
    assign mx_l = max_o[l*LANE_W +: LANE_W];

    AST_LZC_ZERO_LANE: assert property (@(posedge clk) disable iff (rst)
      (a_l == '0) |-> (lz_l == LANE_W'(LANE_W))); // R7
    AST_LZC_BELOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
      (a_l != '0) |-> (lz_l < LANE_W'(LANE_W))); // R7
    AST_MIN_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (rst)
      sgn ? ($signed(mn_l) <= $signed(mx_l)) : (mn_l <= mx_l)); // R4
  end

endmodule

// File: rtl/simd_funnel.sv
// 256-to-128 window extraction over the concatenation {hi, lo}.
module simd_funnel #(
  parameter int DATA_W = 128,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  input  logic [AMT_W-1:0]  amt,
  input  logic              in_bytes,
  output logic [DATA_W-1:0] win
);
  localparam int BYTE_AMT_W = AMT_W - 3;

  logic [AMT_W-1:0]    sh;
  logic [2*DATA_W-1:0] cat;

  always_comb begin
    sh  = in_bytes ? {amt[BYTE_AMT_W-1:0], 3'b000} : amt;
    cat = {hi, lo} >> sh;
    win = cat[DATA_W-1:0];
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int HALF_W = 64,
  parameter int SEG_W  = 8,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [1:0]        lane_sz,
  input  logic              sgn,
  input  logic [1:0]        shift_kind,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [AMT_W-1:0]  fsh_amt,
  input  logic              fsh_bytes,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NHALF = DATA_W / HALF_W;

  logic [1:0]        wsel;
  logic [DATA_W-1:0] addsub_r;
  logic [DATA_W-1:0] fsh_r;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] min_r [NUM_SIZES];
  logic [DATA_W-1:0] max_r [NUM_SIZES];
  logic [DATA_W-1:0] shf_r [NUM_SIZES];
  logic [DATA_W-1:0] lzc_r [NUM_SIZES];

  assign wsel = (lane_sz == 2'd3) ? 2'd2 : lane_sz;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    simd_seg_adder #(.W(HALF_W), .SEG_W(SEG_W)) u_add (
      .a   (src_a[h*HALF_W +: HALF_W]),
      .b   (src_b[h*HALF_W +: HALF_W]),
      .sub (op == OP_SUB),
      .wsel(wsel),
      .sum (addsub_r[h*HALF_W +: HALF_W])
    );
  end

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    simd_lane_ops #(.DATA_W(DATA_W), .LANE_W(SEG_W << g)) u_lanes (
      .clk       (clk),
      .rst       (rst),
      .a         (src_a),
      .b         (src_b),
      .sgn       (sgn),
      .shift_kind(shift_kind),
      .min_o     (min_r[g]),
      .max_o     (max_r[g]),
      .shf_o     (shf_r[g]),
      .lzc_o     (lzc_r[g])
    );
  end

  simd_funnel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_funnel (
    .hi      (src_a),
    .lo      (src_b),
    .amt     (fsh_amt),
    .in_bytes(fsh_bytes),
    .win     (fsh_r)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: nxt = addsub_r;
      OP_MIN:         nxt = min_r[wsel];
      OP_MAX:         nxt = max_r[wsel];
      OP_SHF:         nxt = shf_r[wsel];
      OP_AND:         nxt = src_a & src_b;
      OP_OR:          nxt = src_a | src_b;
      OP_XOR:         nxt = src_a ^ src_b;
      OP_NOR:         nxt = ~(src_a | src_b);
      OP_LZC:         nxt = lzc_r[wsel];
      OP_FSH:         nxt = fsh_r;
      default:        nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  AST_OUT_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid)); // R1
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R1
  AST_FUNNEL_ZERO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_FSH && !fsh_bytes && fsh_amt == '0) |=> (result == $past(src_b))); // R8
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 4'd10) |=> (result == '0)); // R9
  AST_SAME_OPERAND_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SUB && src_a == src_b) |=> (result == '0)); // R3

endmodule

// File: tb/simd_alu_bench.sv
module simd_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [3:0]    op = '0;
  logic [1:0]    lane_sz = '0;
  logic          sgn = 1'b0;
  logic [1:0]    shift_kind = '0;
  logic [DW-1:0] src_a = '0;
  logic [DW-1:0] src_b = '0;
  logic [6:0]    fsh_amt = '0;
  logic          fsh_bytes = 1'b0;
  logic          out_valid;
  logic [DW-1:0] result;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] last_exp;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_alu u_simd_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .sgn(sgn), .shift_kind(shift_kind), .src_a(src_a), .src_b(src_b),
    .fsh_amt(fsh_amt), .fsh_bytes(fsh_bytes), .out_valid(out_valid), .result(result)
  );

  function automatic logic [DW-1:0] model(
      input logic [3:0] o, input logic [1:0] ls, input logic sg, input logic [1:0] sk,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [6:0] fa, input logic fb);
    int lw;
    logic [DW-1:0] r;
    logic [63:0] mask, x, y, v;
    longint xs, ys;
    int s, n;
    logic [255:0] cat;
    lw = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
    mask = (64'd1 << lw) - 64'd1;
    r = '0;
    if (o == 4'd5) return a & b;
    if (o == 4'd6) return a | b;
    if (o == 4'd7) return a ^ b;
    if (o == 4'd8) return ~(a | b);
    if (o == 4'd10) begin
      cat = {a, b} >> (fb ? (int'(fa[3:0]) * 8) : int'(fa));
      return cat[DW-1:0];
    end
    if (o > 4'd10) return '0;
    for (int l = 0; l < DW / lw; l++) begin
      x = 64'(a >> (l * lw)) & mask;
      y = 64'(b >> (l * lw)) & mask;
      xs = x[lw-1] ? longint'(x) - (longint'(1) <<< lw) : longint'(x);
      ys = y[lw-1] ? longint'(y) - (longint'(1) <<< lw) : longint'(y);
      s = int'(y % 64'(lw));
      case (o)
        4'd0: v = (x + y) & mask;
        4'd1: v = (x - y) & mask;
        4'd2: v = (sg ? (xs < ys) : (x < y)) ? x : y;
        4'd3: v = (sg ? (xs < ys) : (x < y)) ? y : x;
        4'd4: begin
          if (sk == 2'd1) v = x >> s;
          else if (sk == 2'd2) v = 64'(xs >>> s) & mask;
          else v = (x << s) & mask;
        end
        default: begin
          n = lw;
          for (int i = 0; i < lw; i++) if (x[i]) n = lw - 1 - i;
          v = 64'(n);
        end
      endcase
      r = r | (DW'(v) << (l * lw));
    end
    return r;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [1:0] ls, input logic sg,
                       input logic [1:0] sk, input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [6:0] fa, input logic fb, input string tag);
    @(negedge clk);
    op = o; lane_sz = ls; sgn = sg; shift_kind = sk;
    src_a = a; src_b = b; fsh_amt = fa; fsh_bytes = fb;
    in_valid = 1'b1;
    last_exp = model(o, ls, sg, sk, a, b, fa, fb);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected out_valid", result, '0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(result === e, t, result, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", result, '0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0 && result == '0, "R1 reset state", result, '0);

    // R3 lane-contained wrap, all widths
    drive(4'd0, 2'd0, 0, 0, {16{8'hFF}}, {16{8'h01}}, 0, 0, "R3 add 8-bit wrap");
    drive(4'd0, 2'd1, 0, 0, {8{16'hFFFF}}, {8{16'h0001}}, 0, 0, "R3 add 16-bit wrap");
    drive(4'd0, 2'd2, 0, 0, {4{32'hFFFF_FFFF}}, {4{32'h1}}, 0, 0, "R3 add 32-bit wrap");
    drive(4'd1, 2'd0, 0, 0, {16{8'h00}}, {16{8'h01}}, 0, 0, "R3 sub 8-bit borrow");
    drive(4'd1, 2'd2, 0, 0, {4{32'h0000_0001}}, {4{32'h0000_0002}}, 0, 0, "R3 sub 32-bit borrow");
    // R2 lane_sz 3 behaves as 32
    drive(4'd0, 2'd3, 0, 0, {4{32'h0000_FFFF}}, {4{32'h0000_0001}}, 0, 0, "R2 lane_sz 3 as 32");
    // R4 signed vs unsigned
    drive(4'd2, 2'd0, 1, 0, {16{8'h80}}, {16{8'h01}}, 0, 0, "R4 signed min");
    drive(4'd2, 2'd0, 0, 0, {16{8'h80}}, {16{8'h01}}, 0, 0, "R4 unsigned min");
    drive(4'd3, 2'd1, 1, 0, {8{16'hFFFF}}, {8{16'h0002}}, 0, 0, "R4 signed max");
    drive(4'd3, 2'd2, 0, 0, {4{32'hFFFF_FFFF}}, {4{32'h2}}, 0, 0, "R4 unsigned max");
    // R5 shifts, amounts beyond lane width wrap
    drive(4'd4, 2'd0, 0, 2'd0, {16{8'h81}}, {16{8'h09}}, 0, 0, "R5 sll mod width");
    drive(4'd4, 2'd1, 0, 2'd1, {8{16'h8000}}, {8{16'h0014}}, 0, 0, "R5 srl");
    drive(4'd4, 2'd2, 0, 2'd2, {4{32'h8000_0000}}, {4{32'h0000_001F}}, 0, 0, "R5 sra");
    drive(4'd4, 2'd0, 0, 2'd3, {16{8'h03}}, {16{8'h02}}, 0, 0, "R5 kind 3 as sll");
    // R6 logic
    drive(4'd5, 2'd0, 0, 0, {2{64'hF0F0_1234_5678_9ABC}}, {2{64'h0FF0_FFFF_0000_FFFF}}, 0, 0, "R6 and");
    drive(4'd8, 2'd2, 0, 0, {2{64'hF0F0_1234_5678_9ABC}}, {2{64'h0FF0_FFFF_0000_FFFF}}, 0, 0, "R6 nor");
    // R7 leading zeros incl. zero lanes
    drive(4'd9, 2'd0, 0, 0, 128'h00_01_80_40_00_7F_02_00_FF_00_10_00_00_03_00_08, '0, 0, 0, "R7 lzc 8");
    drive(4'd9, 2'd2, 0, 0, 128'h0000_0000_0000_0001_8000_0000_0001_0000, '0, 0, 0, "R7 lzc 32");
    // R8 funnel windows
    drive(4'd10, 2'd0, 0, 0, {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444},
          {64'h5555_6666_7777_8888, 64'h9999_0000_1234_5678}, 7'd0, 0, "R8 funnel 0");
    drive(4'd10, 2'd0, 0, 0, {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444},
          {64'h5555_6666_7777_8888, 64'h9999_0000_1234_5678}, 7'd64, 0, "R8 funnel 64");
    drive(4'd10, 2'd0, 0, 0, {2{64'h8000_0000_0000_0001}}, {2{64'h8000_0000_0000_0001}}, 7'd127, 0, "R8 funnel 127");
    drive(4'd10, 2'd0, 0, 0, {2{64'h0123_4567_89AB_CDEF}}, {2{64'hFEDC_BA98_7654_3210}}, 7'h73, 1, "R8 funnel bytes");
    // R9 undefined op
    drive(4'd15, 2'd0, 0, 0, {4{32'hDEAD_BEEF}}, {4{32'h1234_5678}}, 0, 0, "R9 undefined op");
    drive(4'd11, 2'd1, 0, 0, {4{32'hDEAD_BEEF}}, {4{32'h1234_5678}}, 0, 0, "R9 undefined op 11");

    // R1 hold while idle
    drive(4'd6, 2'd0, 0, 0, {4{32'h0F0F_0000}}, {4{32'h0000_00F0}}, 0, 0, "R6 or");
    idle(4);
    check(result === last_exp && out_valid == 1'b0, "R1 hold while idle", result, last_exp);

    // random stream
    for (int k = 0; k < 200; k++) begin
      logic [DW-1:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      drive(4'($urandom % 12), 2'($urandom), 1'($urandom), 2'($urandom),
            ra, rb, 7'($urandom), 1'($urandom), "R2 R3 R4 R5 R7 R8 random");
    end
    idle(4);
    check(exp_q.size() == 0, "R1 all results delivered", DW'(exp_q.size()), '0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule